// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler and Watchdog

This block is an 8-bit timer/counter and a watchdog counter that share one 8-bit prescaler. The timer advances on one of two sources. The first is the internal instruction clock, which gives one event on every rising edge of `clk`. The second is an external pin, sampled through a synchronizer, with a selectable active edge. An assignment bit gives the prescaler either to the timer or to the watchdog. The consumer that does not hold the prescaler sees its events directly, at a 1:1 ratio.

Software sets the configuration fields with a single write strobe. It can load and read the count register, and it clears the sticky overflow flag. A clear-watchdog command restarts the watchdog counter. When the watchdog holds the prescaler, the same command also empties the prescaler. Any load of the count register holds the timer still for two instruction cycles. The watchdog time-base is a plain tick strobe. When the watchdog counter wraps, `wdt_timeout` pulses for one cycle.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset the count is 00h, the overflow flag and `wdt_timeout` are 0, and the configuration is internal source, rising edge, prescaler assigned to the watchdog (`cfg_psa`=1), ratio select 7.
- R2: With `cfg_psa`=1, the timer advances by exactly one on every source event. The count never changes by more than one per cycle unless it is loaded.
- R3: With `cfg_psa`=0, the timer advances once per 2^(n+1) source events, where n is the value of `cfg_ps`.
- R4: With `cfg_src_ext`=1, events come from `ext_clk` after a two-flop synchronizer. `cfg_edge_fall`=0 counts rising edges and ignores falling ones. `cfg_edge_fall`=1 counts falling edges and ignores rising ones.
- R5: A count step from FFh to 00h sets `ovf_flag`.
- R6: `ovf_flag` stays set until `flag_clr`. If an overflow and `flag_clr` fall in the same cycle, the flag ends up set.
- R7: `tmr_wr` loads `tmr_wdata` at the next edge. Source events in the following two cycles are dropped. Counting resumes on the third edge.
- R8: When `cfg_psa`=0, `tmr_wr` also empties the prescaler.
- R9: With `cfg_psa`=0, each `wdt_tick` advances the WDT_W-bit watchdog counter. On the 2^WDT_W-th event, `wdt_timeout` is high for exactly one cycle and the counter starts again from zero.
- R10: With `cfg_psa`=1, the watchdog advances once per 2^n ticks, where n is the value of `cfg_ps`.
- R11: `wdt_clr` zeroes the watchdog counter. When `cfg_psa`=1, it also empties the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External count input, asynchronous |
| cfg_wr | input | 1 | Strobe that loads the configuration fields |
| cfg_src_ext | input | 1 | 1 = external pin source, 0 = instruction clock |
| cfg_edge_fall | input | 1 | 1 = count falling pin edges, 0 = count rising edges |
| cfg_psa | input | 1 | 1 = prescaler to watchdog, 0 = prescaler to timer |
| cfg_ps | input | 3 | Prescale ratio select |
| tmr_wr | input | 1 | Count register write strobe |
| tmr_wdata | input | 8 | Count register write data |
| tmr_rdata | output | 8 | Current count |
| flag_clr | input | 1 | Clears the overflow flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | input | 1 | Watchdog time-base strobe |
| wdt_clr | input | 1 | Clear-watchdog command |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The assertions assume that the configuration changes only through `cfg_wr`. They also assume that a pin level on `ext_clk` is held for several clock cycles, so that each level reaches the synchronizer output. The stimulus drives every input on the falling clock edge. It holds each external pin level for at least four cycles. It loads the count register or issues `wdt_clr` before each scenario, so that no prescaler residue from an earlier assignment carries over. The watchdog bounds are driven as back-to-back ticks, one per cycle, on either side of the wrap point.

// File: rtl/tmr_prescale_pkg.sv
package tmr_prescale_pkg;
  localparam int TMR_W = 8;
  localparam int PRE_W = 8;
  localparam int SEL_W = $clog2(PRE_W);

  typedef struct packed {
    logic             src_ext;
    logic             edge_fall;
    logic             psa;
    logic [SEL_W-1:0] ps;
  } tmr_cfg_t;

  localparam tmr_cfg_t CFG_RESET = '{src_ext: 1'b0, edge_fall: 1'b0,
                                     psa: 1'b1, ps: {SEL_W{1'b1}}};

  // Timer tap: fires when the low sel+1 bits are all ones (ratio 2^(sel+1))
  function automatic logic tap_timer(input logic [PRE_W-1:0] pre,
                                     input logic [SEL_W-1:0] sel);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < PRE_W; i++)
      if (i <= int'(sel) && !pre[i]) hit = 1'b0;
    return hit;
  endfunction

  // Watchdog tap: fires when the low sel bits are all ones (ratio 2^sel)
  function automatic logic tap_wdt(input logic [PRE_W-1:0] pre,
                                   input logic [SEL_W-1:0] sel);
    logic hit;
    hit = 1'b1;
    for (int i = 0; i < PRE_W; i++)
      if (i < int'(sel) && !pre[i]) hit = 1'b0;
    return hit;
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic fall_sel,
  output logic evt
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= cur;
    end
  end

  assign evt = fall_sel ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/tmr_shared_prescaler.sv
module tmr_shared_prescaler
  import tmr_prescale_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_evt,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_tmr,
  output logic             tap_wd,
  output logic [PRE_W-1:0] pre_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_cnt <= '0;
    else if (clr)    pre_cnt <= '0;
    else if (in_evt) pre_cnt <= pre_cnt + 1'b1;
  end

  assign tap_tmr = in_evt & ~clr & tap_timer(pre_cnt, sel);
  assign tap_wd  = in_evt & ~clr & tap_wdt(pre_cnt, sel);
endmodule

// File: rtl/tmr_wdt_counter.sv
module tmr_wdt_counter #(
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  output logic [WDT_W-1:0] cnt,
  output logic             timeout
);
  localparam logic [WDT_W-1:0] CNT_MAX = {WDT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= evt && (cnt == CNT_MAX);
      if (evt) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_prescale_top.sv
module tmr_prescale_top
  import tmr_prescale_pkg::*;
#(
  parameter int WDT_W   = 8,
  parameter int INH_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             cfg_wr,
  input  logic             cfg_src_ext,
  input  logic             cfg_edge_fall,
  input  logic             cfg_psa,
  input  logic [SEL_W-1:0] cfg_ps,
  input  logic             tmr_wr,
  input  logic [TMR_W-1:0] tmr_wdata,
  output logic [TMR_W-1:0] tmr_rdata,
  input  logic             flag_clr,
  output logic             ovf_flag,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  output logic             wdt_timeout
);
  localparam int INH_W = $clog2(INH_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  tmr_cfg_t         cfg_q;
  logic [TMR_W-1:0] tmr_q;
  logic [INH_W-1:0] inh_q;
  logic             inhibit;
  logic             ext_evt, src_evt, tmr_path_evt;
  logic             pre_in, pre_clr, tap_tmr, tap_wd;
  logic [PRE_W-1:0] pre_cnt;
  logic             tmr_inc, wdt_evt, ovf_evt;
  logic [WDT_W-1:0] wdt_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (cfg_wr) cfg_q <= '{src_ext: cfg_src_ext, edge_fall: cfg_edge_fall,
                                psa: cfg_psa, ps: cfg_ps};
  end

  tmr_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk),
    .fall_sel(cfg_q.edge_fall), .evt(ext_evt)
  );

  assign inhibit      = (inh_q != '0);
  assign src_evt      = cfg_q.src_ext ? ext_evt : 1'b1;
  assign tmr_path_evt = src_evt & ~inhibit;
  assign pre_in       = cfg_q.psa ? wdt_tick : tmr_path_evt;
  assign pre_clr      = cfg_q.psa ? wdt_clr : tmr_wr;

  tmr_shared_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .in_evt(pre_in), .clr(pre_clr),
    .sel(cfg_q.ps), .tap_tmr(tap_tmr), .tap_wd(tap_wd), .pre_cnt(pre_cnt)
  );

  assign tmr_inc = cfg_q.psa ? tmr_path_evt : tap_tmr;
  assign wdt_evt = cfg_q.psa ? tap_wd : wdt_tick;
  assign ovf_evt = tmr_inc & ~tmr_wr & (tmr_q == TMR_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      inh_q <= '0;
    end else if (tmr_wr) begin
      tmr_q <= tmr_wdata;
      inh_q <= INH_W'(INH_CYC);
    end else begin
      if (inhibit) inh_q <= inh_q - 1'b1;
      if (tmr_inc) tmr_q <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_flag <= 1'b0;
    else if (ovf_evt)  ovf_flag <= 1'b1;
    else if (flag_clr) ovf_flag <= 1'b0;
  end

  tmr_wdt_counter #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .evt(wdt_evt), .clr(wdt_clr),
    .cnt(wdt_cnt), .timeout(wdt_timeout)
  );

  assign tmr_rdata = tmr_q;
endmodule

// File: rtl/tmr_prescale_chk.sv
module tmr_prescale_chk
  import tmr_prescale_pkg::*;
#(
  parameter int WDT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_wr,
  input logic [TMR_W-1:0] tmr_wdata,
  input logic [TMR_W-1:0] tmr_rdata,
  input logic             flag_clr,
  input logic             ovf_flag,
  input logic             wdt_clr,
  input logic             wdt_timeout,
  input logic             tmr_inc,
  input logic             psa_now,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [WDT_W-1:0] wdt_cnt
);
  // R2: without a load the count moves by zero or one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wr |=> (tmr_rdata == $past(tmr_rdata)) ||
                (tmr_rdata == TMR_W'($past(tmr_rdata) + 1'b1)));

  // R5: wrap from the top value raises the flag
  a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_inc && !tmr_wr && tmr_rdata == {TMR_W{1'b1}}) |=> ovf_flag);

  // R6: flag persists until cleared
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  // R7: load value appears, then is held during the inhibit
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wr |=> tmr_rdata == $past(tmr_wdata));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tmr_wr) && !tmr_wr) |=> $stable(tmr_rdata));

  // R8: load empties the prescaler when it serves the timer
  a_r8_pre_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_wr && !psa_now) |=> pre_cnt == '0);

  // R9: time-out is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout);

  // R11: clear command zeroes watchdog, and prescaler when assigned
  a_r11_wdt_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> (wdt_cnt == '0) && !wdt_timeout);
  a_r11_pre_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr && psa_now) |=> pre_cnt == '0);
endmodule

bind tmr_prescale_top tmr_prescale_chk #(.WDT_W(WDT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata),
  .tmr_rdata(tmr_rdata), .flag_clr(flag_clr), .ovf_flag(ovf_flag),
  .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout), .tmr_inc(tmr_inc),
  .psa_now(cfg_q.psa), .pre_cnt(pre_cnt), .wdt_cnt(wdt_cnt)
);

// File: tb/tmr_prescale_top_tb.sv
module tmr_prescale_top_tb;
  localparam int WDT_W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       cfg_wr = 1'b0, cfg_src_ext = 1'b0, cfg_edge_fall = 1'b0, cfg_psa = 1'b1;
  logic [2:0] cfg_ps = 3'd7;
  logic       tmr_wr = 1'b0;
  logic [7:0] tmr_wdata = '0;
  logic [7:0] tmr_rdata;
  logic       flag_clr = 1'b0, ovf_flag;
  logic       wdt_tick = 1'b0, wdt_clr = 1'b0, wdt_timeout;

  int checks = 0, failures = 0, to_seen = 0;

  always #10 clk = ~clk;

  tmr_prescale_top #(.WDT_W(WDT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .cfg_wr(cfg_wr),
    .cfg_src_ext(cfg_src_ext), .cfg_edge_fall(cfg_edge_fall), .cfg_psa(cfg_psa),
    .cfg_ps(cfg_ps), .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
    .flag_clr(flag_clr), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick),
    .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout)
  );

  always @(negedge clk) if (rst_n && wdt_timeout) to_seen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input logic ext, input logic fall, input logic psa, input logic [2:0] ps);
    cfg_src_ext = ext; cfg_edge_fall = fall; cfg_psa = psa; cfg_ps = ps;
    cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    tmr_wdata = v; tmr_wr = 1'b1; cyc(1); tmr_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin wdt_tick = 1'b1; cyc(1); end
    wdt_tick = 1'b0;
  endtask

  task automatic clr_wdt();
    wdt_clr = 1'b1; cyc(1); wdt_clr = 1'b0; cyc(1); to_seen = 0;
  endtask

  task automatic t_reset();
    chk("R1 count", tmr_rdata, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 timeout", wdt_timeout, 0);
    cyc(4); // reset config: internal, 1:1
    chk("R1 default 1:1 count", tmr_rdata, 4);
  endtask

  task automatic t_load_inhibit();
    set_cfg(0, 0, 1, 3'd0);
    load(8'd10);
    chk("R7 loaded", tmr_rdata, 10);
    cyc(2); chk("R7 inhibited", tmr_rdata, 10);
    cyc(1); chk("R7 resumes", tmr_rdata, 11);
    cyc(2); chk("R2 one per event", tmr_rdata, 13);
  endtask

  task automatic t_ratio(input logic [2:0] n, input int events);
    set_cfg(0, 0, 0, n);
    load(8'd0);
    cyc(2 + events);
    chk("R3 prescaled count", tmr_rdata, events >> (n + 1));
  endtask

  task automatic t_load_clears_pre();
    set_cfg(0, 0, 0, 3'd1);   // ratio 4
    load(8'd0); cyc(4);       // two events into the prescaler
    load(8'd0); cyc(5);       // three events after reload
    chk("R8 prescaler emptied", tmr_rdata, 0);
    cyc(1);
    chk("R8 fourth event", tmr_rdata, 1);
  endtask

  task automatic pulse_pin(input int n);
    for (int i = 0; i < n; i++) begin ext_clk = 1'b1; cyc(4); ext_clk = 1'b0; cyc(4); end
  endtask

  task automatic t_external();
    set_cfg(1, 0, 1, 3'd0);
    load(8'd0); cyc(3);
    pulse_pin(3); cyc(2);
    chk("R4 rising count", tmr_rdata, 3);
    ext_clk = 1'b1; cyc(5); chk("R4 rising edge counted", tmr_rdata, 4);
    ext_clk = 1'b0; cyc(5); chk("R4 falling ignored", tmr_rdata, 4);
    set_cfg(1, 1, 1, 3'd0); cyc(2);
    ext_clk = 1'b1; cyc(5); chk("R4 rising ignored", tmr_rdata, 4);
    ext_clk = 1'b0; cyc(5); chk("R4 falling counted", tmr_rdata, 5);
  endtask

  task automatic t_overflow();
    set_cfg(0, 0, 1, 3'd0);
    flag_clr = 1'b1; load(8'hFE); flag_clr = 1'b0;
    cyc(3);
    chk("R5 at FF", tmr_rdata, 255);
    chk("R5 no flag yet", ovf_flag, 0);
    cyc(1);
    chk("R5 wrapped", tmr_rdata, 0);
    chk("R5 flag set", ovf_flag, 1);
    cyc(5); chk("R6 flag sticky", ovf_flag, 1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R6 flag cleared", ovf_flag, 0);
    load(8'hFF); cyc(2);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R6 wrap with clear", tmr_rdata, 0);
    chk("R6 set wins", ovf_flag, 1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
  endtask

  task automatic t_wdt_direct();
    set_cfg(0, 0, 0, 3'd3);
    clr_wdt();
    ticks((1 << WDT_W) - 1); cyc(1);
    chk("R9 no timeout before wrap", to_seen, 0);
    ticks(1); cyc(1);
    chk("R9 timeout once", to_seen, 1);
    chk("R9 pulse ended", wdt_timeout, 0);
  endtask

  task automatic t_wdt_prescaled();
    set_cfg(0, 0, 1, 3'd1);   // watchdog ratio 2
    clr_wdt();
    ticks((2 << WDT_W) - 1); cyc(1);
    chk("R10 no timeout at 2N-1", to_seen, 0);
    ticks(1); cyc(1);
    chk("R10 timeout at 2N", to_seen, 1);
    clr_wdt();
    ticks(1);                  // prescaler holds one tick
    clr_wdt();
    ticks((2 << WDT_W) - 1); cyc(1);
    chk("R11 prescaler cleared", to_seen, 0);
    ticks(1); cyc(1);
    chk("R11 timeout after clear", to_seen, 1);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    t_reset();
    t_load_inhibit();
    t_ratio(3'd0, 20);
    t_ratio(3'd2, 64);
    t_ratio(3'd7, 512);
    t_load_clears_pre();
    t_external();
    t_overflow();
    t_wdt_direct();
    t_wdt_prescaled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    failures++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule